// File: doc/BRIEF.md
# Accumulator Virtual CPU Datapath

This block runs the data-processing and memory instructions of a byte-coded virtual machine. The machine has a 16-bit accumulator. Each instruction is a one-byte opcode. Most opcodes are followed by one operand byte D, which names a zero-page location or supplies a small constant. The block fetches instruction bytes through a byte-wide program memory port with combinational reads. It performs zero-page, stack-frame and pointer accesses through a separate byte-wide data memory port. Multi-byte values are stored little-endian, with the low byte at the lower address.

Every instruction occupies a fixed number of clock cycles set by its opcode. The first cycle is the opcode fetch. On the last cycle `done` pulses, the accumulator takes its new value, and the next opcode is fetched in the following cycle.

Control-flow, stack-management and native-call opcodes are not executed here. The block stops and presents such an opcode to an external control unit, then resumes at the address that unit returns. The stack pointer belongs to that unit and arrives as an input. Any other opcode is undefined: it halts the block with an error flag until reset.

Top module: `accvm_top`

## Requirements
- R1: While reset is asserted and right after it is released, `acc` is 0, `progAddr` is 0x0200, and `done`, `illegal` and `ctrlValid` are low.
- R2: The load opcodes behave as follows. 0x1A loads zero-extended byte [D]. 0x59 loads D zero-extended. 0x11 loads the next two bytes, low byte first. 0x21 loads the word [D], [D+1]. The accumulator changes only at the edge that ends a `done` cycle.
- R3: The zero-page word operations, with operand [D] + 256*[D+1], are: 0x99 add and 0xB8 subtract, both modulo 2^16, and 0xF8 AND, 0xFA OR and 0xFC XOR.
- R4: The immediate operations are 0x82 AND, 0x88 OR, 0x8C XOR, 0xE3 add and 0xE6 subtract. 0xE3 and 0xE6 use D zero-extended, modulo 2^16. 0x82 clears the high byte of the accumulator. 0x88 and 0x8C leave the high byte unchanged. 0xE9 shifts the accumulator left by one bit and takes no operand byte.
- R5: 0x5E writes the low accumulator byte to [D]. 0x2B writes the low byte to [D] and the high byte to zero-page address (D+1) mod 256, so D=0xFF places the high byte at 0x0000.
- R6: 0xEC stores the accumulator as a word, and 0xEE loads a word, at zero-page address (spIn+D) mod 256 and the byte after it. Both addresses wrap within the zero page.
- R7: 0x93 replaces zero-page byte [D] with ([D]+1) mod 256. It does not touch [D+1] or the accumulator.
- R8: 0xAD loads the zero-extended byte at the address held in the accumulator. 0xF6 loads the word at that address and the address after it. Neither takes an operand byte.
- R9: 0xF0 writes the low accumulator byte to the 16-bit address P = [D] + 256*[D+1]. 0xF3 writes the low byte to P and the high byte to P+1.
- R10: `done` is high for exactly one cycle. It is raised exactly C cycles after the previous instruction's `done`, where C is 14 for 0x88 and 0x8C; 16 for 0x59, 0x5E, 0x93 and 0x82; 18 for 0x1A; 20 for 0x11, 0x21 and 0x2B; 26 for 0xEC, 0xEE, 0xFC and 0xAD; and 28 for 0x99, 0xB8, 0xE3, 0xE6, 0xE9, 0xF8, 0xFA, 0xF6, 0xF0 and 0xF3.
- R11: A fetched opcode from {0x35, 0x63, 0x75, 0x90, 0xB4, 0xCD, 0xCF, 0xDF, 0xFF} raises `ctrlValid` with that opcode on `ctrlOpcode`. The block then holds `progAddr`, the accumulator and the data port still. A cycle with `ctrlResume` high makes the next fetch come from `ctrlPc`.
- R12: Any other opcode, including 0x00 and 0x7F, sets `illegal`. After that no `done` pulse, data write or control request occurs until reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| progAddr | output | 16 | Program memory byte address |
| progData | input | 8 | Program memory read data (combinational) |
| dataAddr | output | 16 | Data memory byte address |
| dataWdata | output | 8 | Data memory write byte |
| dataWe | output | 1 | Data memory write enable |
| dataRdata | input | 8 | Data memory read data (combinational) |
| spIn | input | 8 | Stack pointer from the control unit |
| ctrlValid | output | 1 | Control opcode waiting for the control unit |
| ctrlOpcode | output | 8 | The waiting control opcode |
| ctrlPc | input | 16 | Resume fetch address |
| ctrlResume | input | 1 | Resume strobe from the control unit |
| acc | output | 16 | Accumulator |
| done | output | 1 | Instruction completion pulse |
| illegal | output | 1 | Undefined opcode seen; block halted |

## Verification
The bench targets the address wraps. A word store at D=0xFF and stack-frame sums past 0xFF test them: a design that carried into the high address byte would write outside the zero page and leave 0x0000 untouched. Immediate AND, OR and XOR are checked against a non-zero high accumulator byte, which exposes a design that masks or keeps the wrong byte. Subtract and add are checked across zero and across 0xFFFF, which exposes lost carries. Cycle counts between completion pulses expose any instruction that ends early or late. The control handoff and the illegal halt are checked for a moving fetch address, stray writes or further completions.

// File: rtl/accvm_pkg.sv
package accvm_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int STEP_W = 5;

  typedef enum logic [4:0] {
    K_LOADZ, K_LOADIMM, K_LOADWIMM, K_LOADWZ, K_LOADWSF,
    K_STOREZ, K_STOREWZ, K_STOREWSF,
    K_ADDZ, K_SUBZ, K_ANDZ, K_ORZ, K_XORZ,
    K_ADDIMM, K_SUBIMM, K_ANDIMM, K_ORIMM, K_XORIMM,
    K_SHL, K_INCZ, K_RDB, K_RDW, K_WRB, K_WRW,
    K_CTRL, K_BAD
  } opKind_e;

  typedef struct packed {
    opKind_e kind;
    logic [STEP_W-1:0] step;
    logic active;
    logic commit;
  } strobe_t;

  function automatic opKind_e decodeOp(input logic [BYTE_W-1:0] op);
    case (op)
      8'h1A: return K_LOADZ;    8'h59: return K_LOADIMM;
      8'h11: return K_LOADWIMM; 8'h21: return K_LOADWZ;
      8'hEE: return K_LOADWSF;  8'h5E: return K_STOREZ;
      8'h2B: return K_STOREWZ;  8'hEC: return K_STOREWSF;
      8'h99: return K_ADDZ;     8'hB8: return K_SUBZ;
      8'hF8: return K_ANDZ;     8'hFA: return K_ORZ;
      8'hFC: return K_XORZ;     8'hE3: return K_ADDIMM;
      8'hE6: return K_SUBIMM;   8'h82: return K_ANDIMM;
      8'h88: return K_ORIMM;    8'h8C: return K_XORIMM;
      8'hE9: return K_SHL;      8'h93: return K_INCZ;
      8'hAD: return K_RDB;      8'hF6: return K_RDW;
      8'hF0: return K_WRB;      8'hF3: return K_WRW;
      8'h35, 8'h63, 8'h75, 8'h90, 8'hB4,
      8'hCD, 8'hCF, 8'hDF, 8'hFF: return K_CTRL;
      default: return K_BAD;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] kindCost(input opKind_e k);
    case (k)
      K_ORIMM, K_XORIMM:                           return 5'd14;
      K_LOADIMM, K_STOREZ, K_INCZ, K_ANDIMM:       return 5'd16;
      K_LOADZ:                                     return 5'd18;
      K_LOADWIMM, K_LOADWZ, K_STOREWZ:             return 5'd20;
      K_STOREWSF, K_LOADWSF, K_XORZ, K_RDB:        return 5'd26;
      default:                                     return 5'd28;
    endcase
  endfunction

  function automatic logic [1:0] kindLen(input opKind_e k);
    case (k)
      K_SHL, K_RDB, K_RDW: return 2'd1;
      K_LOADWIMM:          return 2'd3;
      default:             return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/accvm_seq.sv
module accvm_seq
  import accvm_pkg::*;
#(
  parameter logic [WORD_W-1:0] START_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] progData,
  input  logic [WORD_W-1:0] ctrlPc,
  input  logic              ctrlResume,
  output logic [WORD_W-1:0] progAddr,
  output strobe_t           stb,
  output logic              ctrlValid,
  output logic [BYTE_W-1:0] ctrlOpcode,
  output logic              done,
  output logic              illegal
);
  typedef enum logic [1:0] {S_RUN, S_CTRL, S_HALT} state_e;

  state_e            state;
  logic [WORD_W-1:0] pc;
  logic [STEP_W-1:0] cyc, cost;
  logic [1:0]        len;
  opKind_e           kind, fetchKind;
  logic              lastCyc;

  assign fetchKind = decodeOp(progData);
  assign lastCyc   = (state == S_RUN) && (cyc != '0) && (cyc == cost - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_RUN;
      pc         <= START_PC;
      cyc        <= '0;
      cost       <= '0;
      len        <= '0;
      kind       <= K_BAD;
      ctrlOpcode <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (cyc == '0) begin
            if (fetchKind == K_CTRL) begin
              state      <= S_CTRL;
              ctrlOpcode <= progData;
            end else if (fetchKind == K_BAD) begin
              state <= S_HALT;
            end else begin
              kind <= fetchKind;
              cost <= kindCost(fetchKind);
              len  <= kindLen(fetchKind);
              cyc  <= 5'd1;
            end
          end else if (lastCyc) begin
            cyc <= '0;
            pc  <= pc + {14'b0, len};
          end else begin
            cyc <= cyc + 5'd1;
          end
        end
        S_CTRL: begin
          if (ctrlResume) begin
            pc    <= ctrlPc;
            cyc   <= '0;
            state <= S_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign progAddr   = (cyc < 5'd3) ? pc + {14'b0, cyc[1:0]} : pc;
  assign stb.kind   = kind;
  assign stb.step   = cyc;
  assign stb.active = (state == S_RUN) && (cyc != '0);
  assign stb.commit = lastCyc;
  assign done       = lastCyc;
  assign ctrlValid  = (state == S_CTRL);
  assign illegal    = (state == S_HALT);
endmodule

// File: rtl/accvm_dpath.sv
module accvm_dpath
  import accvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] progData,
  input  logic [BYTE_W-1:0] dataRdata,
  input  logic [BYTE_W-1:0] spIn,
  output logic [WORD_W-1:0] dataAddr,
  output logic [BYTE_W-1:0] dataWdata,
  output logic              dataWe,
  output logic [WORD_W-1:0] acc
);
  logic [WORD_W-1:0] accR, opw, ptr, nextAcc;
  logic [BYTE_W-1:0] dByte;
  logic rdLo, rdHi, ptrLo, ptrHi;
  logic [WORD_W-1:0] zpA, zpB, sfA, sfB;

  assign zpA = {8'h00, dByte};
  assign zpB = {8'h00, dByte + 8'd1};
  assign sfA = {8'h00, spIn + dByte};
  assign sfB = {8'h00, spIn + dByte + 8'd1};

  always_comb begin
    dataAddr = '0; dataWdata = '0; dataWe = 1'b0;
    rdLo = 1'b0; rdHi = 1'b0; ptrLo = 1'b0; ptrHi = 1'b0;
    if (stb.active) begin
      case (stb.kind)
        K_LOADZ: if (stb.step == 5'd2) begin dataAddr = zpA; rdLo = 1'b1; end
        K_LOADWZ, K_ADDZ, K_SUBZ, K_ANDZ, K_ORZ, K_XORZ: begin
          if (stb.step == 5'd2) begin dataAddr = zpA; rdLo = 1'b1; end
          if (stb.step == 5'd3) begin dataAddr = zpB; rdHi = 1'b1; end
        end
        K_LOADWSF: begin
          if (stb.step == 5'd2) begin dataAddr = sfA; rdLo = 1'b1; end
          if (stb.step == 5'd3) begin dataAddr = sfB; rdHi = 1'b1; end
        end
        K_STOREZ: if (stb.step == 5'd2) begin
          dataAddr = zpA; dataWdata = accR[7:0]; dataWe = 1'b1;
        end
        K_STOREWZ, K_STOREWSF: begin
          if (stb.step == 5'd2) begin
            dataAddr = (stb.kind == K_STOREWZ) ? zpA : sfA;
            dataWdata = accR[7:0]; dataWe = 1'b1;
          end
          if (stb.step == 5'd3) begin
            dataAddr = (stb.kind == K_STOREWZ) ? zpB : sfB;
            dataWdata = accR[15:8]; dataWe = 1'b1;
          end
        end
        K_INCZ: begin
          if (stb.step == 5'd2) begin dataAddr = zpA; rdLo = 1'b1; end
          if (stb.step == 5'd3) begin
            dataAddr = zpA; dataWdata = opw[7:0] + 8'd1; dataWe = 1'b1;
          end
        end
        K_RDB: if (stb.step == 5'd2) begin dataAddr = accR; rdLo = 1'b1; end
        K_RDW: begin
          if (stb.step == 5'd2) begin dataAddr = accR; rdLo = 1'b1; end
          if (stb.step == 5'd3) begin dataAddr = accR + 16'd1; rdHi = 1'b1; end
        end
        K_WRB, K_WRW: begin
          if (stb.step == 5'd2) begin dataAddr = zpA; ptrLo = 1'b1; end
          if (stb.step == 5'd3) begin dataAddr = zpB; ptrHi = 1'b1; end
          if (stb.step == 5'd4) begin
            dataAddr = ptr; dataWdata = accR[7:0]; dataWe = 1'b1;
          end
          if (stb.step == 5'd5 && stb.kind == K_WRW) begin
            dataAddr = ptr + 16'd1; dataWdata = accR[15:8]; dataWe = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (stb.kind)
      K_LOADZ, K_RDB:                nextAcc = {8'h00, opw[7:0]};
      K_LOADIMM:                     nextAcc = {8'h00, dByte};
      K_LOADWIMM:                    nextAcc = {opw[15:8], dByte};
      K_LOADWZ, K_LOADWSF, K_RDW:    nextAcc = opw;
      K_ADDZ:                        nextAcc = accR + opw;
      K_SUBZ:                        nextAcc = accR - opw;
      K_ANDZ:                        nextAcc = accR & opw;
      K_ORZ:                         nextAcc = accR | opw;
      K_XORZ:                        nextAcc = accR ^ opw;
      K_ADDIMM:                      nextAcc = accR + {8'h00, dByte};
      K_SUBIMM:                      nextAcc = accR - {8'h00, dByte};
      K_ANDIMM:                      nextAcc = {8'h00, accR[7:0] & dByte};
      K_ORIMM:                       nextAcc = {accR[15:8], accR[7:0] | dByte};
      K_XORIMM:                      nextAcc = {accR[15:8], accR[7:0] ^ dByte};
      K_SHL:                         nextAcc = {accR[14:0], 1'b0};
      default:                       nextAcc = accR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accR <= '0; opw <= '0; ptr <= '0; dByte <= '0;
    end else begin
      if (stb.active && stb.step == 5'd1) dByte <= progData;
      if (stb.active && stb.step == 5'd2 && stb.kind == K_LOADWIMM) opw[15:8] <= progData;
      if (rdLo)  opw[7:0]  <= dataRdata;
      if (rdHi)  opw[15:8] <= dataRdata;
      if (ptrLo) ptr[7:0]  <= dataRdata;
      if (ptrHi) ptr[15:8] <= dataRdata;
      if (stb.commit) accR <= nextAcc;
    end
  end

  assign acc = accR;
endmodule

// File: rtl/accvm_top.sv
module accvm_top
  import accvm_pkg::*;
#(
  parameter logic [15:0] START_PC = 16'h0200
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] progAddr,
  input  logic [7:0]  progData,
  output logic [15:0] dataAddr,
  output logic [7:0]  dataWdata,
  output logic        dataWe,
  input  logic [7:0]  dataRdata,
  input  logic [7:0]  spIn,
  output logic        ctrlValid,
  output logic [7:0]  ctrlOpcode,
  input  logic [15:0] ctrlPc,
  input  logic        ctrlResume,
  output logic [15:0] acc,
  output logic        done,
  output logic        illegal
);
  strobe_t stb;

  accvm_seq #(.START_PC(START_PC)) seq_i (
    .clk(clk), .rst_n(rst_n), .progData(progData), .ctrlPc(ctrlPc),
    .ctrlResume(ctrlResume), .progAddr(progAddr), .stb(stb),
    .ctrlValid(ctrlValid), .ctrlOpcode(ctrlOpcode), .done(done),
    .illegal(illegal)
  );

  accvm_dpath dpath_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .progData(progData),
    .dataRdata(dataRdata), .spIn(spIn), .dataAddr(dataAddr),
    .dataWdata(dataWdata), .dataWe(dataWe), .acc(acc)
  );
endmodule

// File: rtl/accvm_chk.sv
module accvm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        illegal,
  input logic        ctrlValid,
  input logic        ctrlResume,
  input logic        dataWe,
  input logic [15:0] progAddr,
  input logic [15:0] acc
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);
  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!dataWe && !done && !ctrlValid));
  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlValid && !ctrlResume) |=> (ctrlValid && $stable(progAddr) && $stable(acc)));
  // R11
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlValid |-> (!dataWe && !done));
  // R2
  acc_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc) |-> $past(done));
endmodule

bind accvm_top accvm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .illegal(illegal),
  .ctrlValid(ctrlValid), .ctrlResume(ctrlResume), .dataWe(dataWe),
  .progAddr(progAddr), .acc(acc)
);

// File: tb/accvm_top_tb_top.sv
module accvm_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] progAddr, dataAddr, acc, ctrlPc;
  logic [7:0]  progData, dataWdata, dataRdata, spIn, ctrlOpcode;
  logic dataWe, ctrlValid, ctrlResume, done, illegal;

  logic [7:0] prog [0:1023];
  logic [7:0] dmem [0:1023];
  int cycCnt = 0, nChecks = 0, nFails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;
  always @(posedge clk) if (dataWe) dmem[dataAddr[9:0]] <= dataWdata;
  assign progData  = prog[progAddr[9:0]];
  assign dataRdata = dmem[dataAddr[9:0]];

  accvm_top dut_i (
    .clk(clk), .rst_n(rst_n), .progAddr(progAddr), .progData(progData),
    .dataAddr(dataAddr), .dataWdata(dataWdata), .dataWe(dataWe),
    .dataRdata(dataRdata), .spIn(spIn), .ctrlValid(ctrlValid),
    .ctrlOpcode(ctrlOpcode), .ctrlPc(ctrlPc), .ctrlResume(ctrlResume),
    .acc(acc), .done(done), .illegal(illegal)
  );

  // op, d, initial acc, zero-page word at d, expected acc, cycle cost
  typedef struct packed {
    logic [7:0] op; logic [7:0] d; logic [15:0] init;
    logic [15:0] mem; logic [15:0] exp; logic [7:0] cost;
  } vec_t;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h1A, 8'h30, 16'h1234, 16'h77A5, 16'h00A5, 8'd18},
    '{8'h59, 8'hC8, 16'hFFFF, 16'h0000, 16'h00C8, 8'd16},
    '{8'h21, 8'h30, 16'h0000, 16'hBEEF, 16'hBEEF, 8'd20},
    '{8'h99, 8'h30, 16'hFFF0, 16'h0020, 16'h0010, 8'd28},
    '{8'hB8, 8'h30, 16'h0005, 16'h0007, 16'hFFFE, 8'd28},
    '{8'hF8, 8'h30, 16'hF0F0, 16'h3C3C, 16'h3030, 8'd28},
    '{8'hFA, 8'h30, 16'hF0F0, 16'h0F01, 16'hFFF1, 8'd28},
    '{8'hFC, 8'h30, 16'hFF00, 16'h0FF0, 16'hF0F0, 8'd26},
    '{8'hE3, 8'h80, 16'h00FF, 16'h0000, 16'h017F, 8'd28},
    '{8'hE6, 8'h01, 16'h0000, 16'h0000, 16'hFFFF, 8'd28},
    '{8'h82, 8'h0F, 16'hABCD, 16'h0000, 16'h000D, 8'd16},
    '{8'h88, 8'hF0, 16'hAB0D, 16'h0000, 16'hABFD, 8'd14},
    '{8'h8C, 8'hFF, 16'hAB0F, 16'h0000, 16'hABF0, 8'd14},
    '{8'hE9, 8'h00, 16'hC001, 16'h0000, 16'h8002, 8'd28}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < 1024; i++) begin prog[i] = 8'h00; dmem[i] = 8'h00; end
  endtask

  task automatic pulseReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic waitDone(input string tag, output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 300);
    if (!done) check({tag, " timeout"}, 32'd0, 32'd1);
    t = cycCnt;
  endtask

  task automatic putLoadW(input int a, input logic [15:0] v);
    prog[a] = 8'h11; prog[a+1] = v[7:0]; prog[a+2] = v[15:8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int t0, t1, bad;
    spIn = 8'hF0; ctrlPc = 16'h0000; ctrlResume = 1'b0;

    // R1 reset state
    clearAll(); putLoadW(16'h200, 16'h1111);
    pulseReset();
    check("R1 acc", {16'h0, acc}, 32'h0);
    check("R1 progAddr", {16'h0, progAddr}, 32'h0200);
    check("R1 flags", {29'h0, done, illegal, ctrlValid}, 32'h0);

    // R2 R3 R4 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i < 3) ? "R2" : (i < 8) ? "R3" : "R4";
      clearAll();
      putLoadW(16'h200, VECS[i].init);
      prog[16'h203] = VECS[i].op; prog[16'h204] = VECS[i].d;
      dmem[VECS[i].d] = VECS[i].mem[7:0];
      dmem[(VECS[i].d + 1) % 1024] = VECS[i].mem[15:8];
      pulseReset();
      waitDone(tag, t0);
      waitDone(tag, t1);
      check("R10 cost", t1 - t0, {24'h0, VECS[i].cost});
      @(negedge clk);
      check(tag, {16'h0, acc}, {16'h0, VECS[i].exp});
      check("R10 pulse", {31'h0, done}, 32'h0);
    end

    // R5 word store wrap at D=0xFF, byte store
    clearAll(); putLoadW(16'h200, 16'hC35A);
    prog[16'h203] = 8'h2B; prog[16'h204] = 8'hFF;
    prog[16'h205] = 8'h5E; prog[16'h206] = 8'h40;
    pulseReset();
    waitDone("R5", t0); waitDone("R5", t1);
    check("R10 word store cost", t1 - t0, 32'd20);
    check("R5 low at FF", {24'h0, dmem[16'hFF]}, 32'h5A);
    check("R5 high wraps to 00", {24'h0, dmem[0]}, 32'hC3);
    check("R5 nothing at 100", {24'h0, dmem[16'h100]}, 32'h00);
    waitDone("R5", t0);
    check("R10 byte store cost", t0 - t1, 32'd16);
    check("R5 byte store", {16'h0, dmem[16'h41], dmem[16'h40]}, 32'h005A);

    // R6 stack frame wrap: sp=F0
    clearAll(); putLoadW(16'h200, 16'h1234);
    prog[16'h203] = 8'hEC; prog[16'h204] = 8'h18;
    prog[16'h205] = 8'hEE; prog[16'h206] = 8'h1F;
    dmem[16'h0F] = 8'h99; dmem[16'h10] = 8'h88;
    pulseReset();
    waitDone("R6", t0); waitDone("R6", t1);
    check("R10 frame store cost", t1 - t0, 32'd26);
    check("R6 frame store", {16'h0, dmem[16'h09], dmem[16'h08]}, 32'h1234);
    waitDone("R6", t0);
    check("R10 frame load cost", t0 - t1, 32'd26);
    @(negedge clk);
    check("R6 frame load", {16'h0, acc}, 32'h8899);

    // R7 increment in place
    clearAll(); putLoadW(16'h200, 16'h4321);
    prog[16'h203] = 8'h93; prog[16'h204] = 8'h50;
    dmem[16'h50] = 8'hFF; dmem[16'h51] = 8'h07;
    pulseReset();
    waitDone("R7", t0); waitDone("R7", t1);
    check("R10 inc cost", t1 - t0, 32'd16);
    @(negedge clk);
    check("R7 byte wraps", {16'h0, dmem[16'h51], dmem[16'h50]}, 32'h0700);
    check("R7 acc kept", {16'h0, acc}, 32'h4321);

    // R8 reads through accumulator
    clearAll(); putLoadW(16'h200, 16'h0300);
    prog[16'h203] = 8'hF6;
    putLoadW(16'h204, 16'h0301);
    prog[16'h207] = 8'hAD;
    dmem[16'h300] = 8'h11; dmem[16'h301] = 8'h22;
    pulseReset();
    waitDone("R8", t0); waitDone("R8", t1);
    check("R10 word read cost", t1 - t0, 32'd28);
    waitDone("R8", t0);
    check("R8 word read", {16'h0, acc}, 32'h2211);
    waitDone("R8", t1);
    check("R10 byte read cost", t1 - t0, 32'd26);
    @(negedge clk);
    check("R8 byte read", {16'h0, acc}, 32'h0022);

    // R9 writes through zero-page pointer
    clearAll(); putLoadW(16'h200, 16'hBEEF);
    prog[16'h203] = 8'hF3; prog[16'h204] = 8'h40;
    putLoadW(16'h205, 16'h0077);
    prog[16'h208] = 8'hF0; prog[16'h209] = 8'h40;
    dmem[16'h40] = 8'h10; dmem[16'h41] = 8'h03;
    pulseReset();
    waitDone("R9", t0); waitDone("R9", t1);
    check("R10 word write cost", t1 - t0, 32'd28);
    check("R9 word write", {16'h0, dmem[16'h311], dmem[16'h310]}, 32'hBEEF);
    waitDone("R9", t0); waitDone("R9", t1);
    check("R10 byte write cost", t1 - t0, 32'd28);
    check("R9 byte write", {16'h0, dmem[16'h311], dmem[16'h310]}, 32'hBE77);

    // R11 control handoff
    clearAll(); putLoadW(16'h200, 16'h5555);
    prog[16'h203] = 8'h90; prog[16'h204] = 8'h10;
    prog[16'h250] = 8'h59; prog[16'h251] = 8'h07;
    pulseReset();
    waitDone("R11", t0);
    @(negedge clk); @(negedge clk);
    check("R11 request", {23'h0, ctrlValid, ctrlOpcode}, 32'h190);
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (progAddr !== 16'h0203 || done || dataWe || !ctrlValid) bad++;
    end
    check("R11 held", bad, 0);
    check("R11 acc kept", {16'h0, acc}, 32'h5555);
    ctrlPc = 16'h0250; ctrlResume = 1'b1;
    @(negedge clk);
    ctrlResume = 1'b0;
    check("R11 resume addr", {15'h0, ctrlValid, progAddr}, 32'h0250);
    waitDone("R11", t1);
    @(negedge clk);
    check("R11 resumed instr", {16'h0, acc}, 32'h0007);

    // R12 undefined opcode halts until reset
    clearAll(); putLoadW(16'h200, 16'h1111);
    prog[16'h203] = 8'h7F; prog[16'h204] = 8'h30;
    pulseReset();
    waitDone("R12", t0);
    @(negedge clk); @(negedge clk);
    check("R12 flag", {31'h0, illegal}, 32'h1);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (done || dataWe || ctrlValid || !illegal) bad++;
    end
    check("R12 quiet", bad, 0);
    check("R12 acc kept", {16'h0, acc}, 32'h1111);
    pulseReset();
    check("R12 cleared by reset", {31'h0, illegal}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule